// File: doc/BRIEF.md
# General-Purpose Event and Hotplug Slot Registers

This block holds a 16-bit general-purpose event status register and a matching enable register, both reached one byte at a time. Status bits are cleared by writing ones; enable bytes are simply replaced. Next to them sit two 32-bit slot bitmaps that record which slot was most recently inserted or removed. A word-wide eject register turns a written slot mask into a one-cycle eject strobe carrying the index of the lowest set bit.

A hotplug request carries a slot number and an insert/remove flag. It wipes both bitmaps, sets the slot's bit in the inserted or removed bitmap, and raises event status bit 1. If enable bit 1 is set, the block raises the interrupt output for exactly one cycle. Firmware reads the bitmaps to find the slot, acknowledges the event by clearing status bit 1, and may write the eject register to ask for a device to be detached. The detach itself happens outside the block.

Top module: `gpe_hotplug_events`

## Requirements
- R1: After reset, event status, event enable and both slot bitmaps read as 0, and `sci` and `eject_stb` are low.
- R2: Byte reads are combinational. Address 0 returns status[7:0], 1 returns status[15:8], 2 returns enable[7:0] and 3 returns enable[15:8]. Address bit 0 picks the high byte and bit 1 picks enable over status.
- R3: A byte write to address 0 or 1 clears, in the next cycle, each status bit written as 1 in that byte. Bits in the other byte, and bits written as 0, keep their value.
- R4: A byte write to address 2 or 3 replaces that enable byte from the next cycle. The other enable byte is unchanged.
- R5: Word reads are combinational. Offset 0 returns the inserted-slot bitmap and offset 4 returns the removed-slot bitmap; both are replaced by a word write to the same offset. Offset 8 (eject) and every other offset read as 0, and writes to offsets other than 0, 4 and 8 change nothing.
- R6: One cycle after a hotplug request, both bitmaps hold zero except for bit `hp_slot`. That bit is set in the inserted bitmap when `hp_insert` is 1 and in the removed bitmap when it is 0. Status bit 1 is also set.
- R7: `sci` is high in the cycle after a hotplug request exactly when enable bit 1, as updated by any byte write in the same cycle, is 1. At all other times `sci` is low.
- R8: A word write to offset 8 with a nonzero value gives `eject_stb` high for the next cycle only, with `eject_slot` equal to the index of the lowest set bit of the value. A write of zero gives no strobe.
- R9: When a register write and a hotplug request fall in the same cycle, the hotplug update is applied last. Status bit 1 ends set even if the same write clears it, and the bitmaps hold only the hotplug slot even if one of them is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_wr | input | 1 | Byte register write strobe |
| byte_addr | input | 2 | Byte register address, for both read and write |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data for `byte_addr` |
| word_wr | input | 1 | Word register write strobe |
| word_addr | input | 4 | Word register byte offset, for both read and write |
| word_wdata | input | 32 | Word write data |
| word_rdata | output | 32 | Word read data for `word_addr` |
| hp_req | input | 1 | Hotplug request, one cycle per event |
| hp_slot | input | 5 | Slot number of the request |
| hp_insert | input | 1 | 1 for insertion, 0 for removal |
| sci | output | 1 | One-cycle event interrupt pulse |
| eject_stb | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot index for the eject request |

## Verification
The assertions assume that every input is a clean level sampled at the clock edge, and that `hp_slot` is in range whenever `hp_req` is high. Under those assumptions a request always leaves exactly one bitmap bit set. They also take status bits to be set only by hotplug requests. The stimulus changes inputs only on the falling edge. It draws slot numbers from the full 5-bit range and mixes random writes, including simultaneous writes and requests, with directed cases at slots 0 and 31 and eject values of zero, a single bit and several bits.

// File: rtl/gpe_hp_pkg.sv
package gpe_hp_pkg;
  localparam int GPE_W    = 16;
  localparam int LANES    = GPE_W / 8;
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BADDR_W  = $clog2(2 * LANES);
  localparam int SLOT_N   = 32;
  localparam int SLOT_W   = $clog2(SLOT_N);
  localparam int WADDR_W  = 4;
  localparam int HP_BIT   = 1;
  localparam logic [WADDR_W-1:0] OFF_INS   = 4'h0;
  localparam logic [WADDR_W-1:0] OFF_REM   = 4'h4;
  localparam logic [WADDR_W-1:0] OFF_EJECT = 4'h8;

  function automatic logic [SLOT_W-1:0] lowest_set(input logic [SLOT_N-1:0] v);
    lowest_set = '0;
    for (int i = SLOT_N - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = SLOT_W'(i);
    end
  endfunction
endpackage

// File: rtl/gpe_hp_rst_sync.sv
module gpe_hp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/gpe_hp_byte_regs.sv
module gpe_hp_byte_regs
  import gpe_hp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BADDR_W-1:0] addr,
  input  logic [7:0]         wdata,
  input  logic               hp_set,
  output logic [7:0]         rdata,
  output logic [GPE_W-1:0]   en_nxt
);
  logic [GPE_W-1:0] sts_q, en_q, sts_wr, sts_nxt;
  logic             en_clk, reg_sel;
  logic [LANE_W-1:0] lane_sel;
  logic [GPE_W-1:0] rd_vec;

  assign reg_sel  = addr[BADDR_W-1];
  assign lane_sel = LANE_W'(addr[BADDR_W-2:0]);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit;
    assign hit = wr_en && (lane_sel == LANE_W'(l));
    assign sts_wr[l*8 +: 8] = (hit && !reg_sel) ? (sts_q[l*8 +: 8] & ~wdata)
                                                : sts_q[l*8 +: 8];
    assign en_nxt[l*8 +: 8] = (hit && reg_sel) ? wdata : en_q[l*8 +: 8];
  end

  always_comb begin
    sts_nxt = sts_wr;
    if (hp_set) sts_nxt[HP_BIT] = 1'b1;
  end

  assign en_clk = wr_en || hp_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else if (en_clk) begin
      sts_q <= sts_nxt;
      en_q  <= en_nxt;
    end
  end

  assign rd_vec = reg_sel ? en_q : sts_q;
  assign rdata  = rd_vec[lane_sel*8 +: 8];

  p_hp_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hp_set |=> sts_q[HP_BIT]);
  p_status_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_set |=> ((sts_q & ~$past(sts_q)) == '0));
  p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/gpe_hp_slot_maps.sv
module gpe_hp_slot_maps
  import gpe_hp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] addr,
  input  logic [SLOT_N-1:0]  wdata,
  input  logic               hp_req,
  input  logic [SLOT_W-1:0]  hp_slot,
  input  logic               hp_insert,
  output logic [SLOT_N-1:0]  rdata
);
  logic [SLOT_N-1:0] ins_q, rem_q, ins_nxt, rem_nxt, slot_bit;
  logic              en_clk;

  assign slot_bit = SLOT_N'(1) << hp_slot;

  always_comb begin
    ins_nxt = ins_q;
    rem_nxt = rem_q;
    if (wr_en && addr == OFF_INS) ins_nxt = wdata;
    if (wr_en && addr == OFF_REM) rem_nxt = wdata;
    if (hp_req) begin
      ins_nxt = hp_insert ? slot_bit : '0;
      rem_nxt = hp_insert ? '0 : slot_bit;
    end
  end

  assign en_clk = wr_en || hp_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= '0;
      rem_q <= '0;
    end else if (en_clk) begin
      ins_q <= ins_nxt;
      rem_q <= rem_nxt;
    end
  end

  always_comb begin
    unique case (addr)
      OFF_INS: rdata = ins_q;
      OFF_REM: rdata = rem_q;
      default: rdata = '0;
    endcase
  end

  p_hp_one_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hp_req |=> ($countones(ins_q | rem_q) == 1));
  p_hp_direction_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_req && hp_insert) |=> (rem_q == '0));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_req && !wr_en) |=> ($stable(ins_q) && $stable(rem_q)));
endmodule

// File: rtl/gpe_hp_eject.sv
module gpe_hp_eject
  import gpe_hp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] addr,
  input  logic [SLOT_N-1:0]  wdata,
  output logic               stb,
  output logic [SLOT_W-1:0]  slot
);
  logic hit;
  logic stb_q;
  logic [SLOT_W-1:0] slot_q;

  assign hit = wr_en && (addr == OFF_EJECT) && (wdata != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   slot_q <= '0;
    else if (hit) slot_q <= lowest_set(wdata);
  end

  assign stb  = stb_q;
  assign slot = slot_q;

  p_eject_bit_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ((($past(wdata) >> slot) & SLOT_N'(1)) == SLOT_N'(1)));
  p_eject_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (($past(wdata) & ((SLOT_N'(1) << slot) - SLOT_N'(1))) == '0));
  p_eject_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_EJECT && wdata == '0) |=> !stb);
endmodule

// File: rtl/gpe_hotplug_events.sv
module gpe_hotplug_events
  import gpe_hp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_wr,
  input  logic [1:0]   byte_addr,
  input  logic [7:0]   byte_wdata,
  output logic [7:0]   byte_rdata,
  input  logic         word_wr,
  input  logic [3:0]   word_addr,
  input  logic [31:0]  word_wdata,
  output logic [31:0]  word_rdata,
  input  logic         hp_req,
  input  logic [4:0]   hp_slot,
  input  logic         hp_insert,
  output logic         sci,
  output logic         eject_stb,
  output logic [4:0]   eject_slot
);
  logic             rst_n_i;
  logic [GPE_W-1:0] en_nxt;
  logic             sci_q;

  gpe_hp_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  gpe_hp_byte_regs u_bytes (
    .clk(clk), .rst_n(rst_n_i), .wr_en(byte_wr), .addr(byte_addr),
    .wdata(byte_wdata), .hp_set(hp_req), .rdata(byte_rdata), .en_nxt(en_nxt)
  );

  gpe_hp_slot_maps u_maps (
    .clk(clk), .rst_n(rst_n_i), .wr_en(word_wr), .addr(word_addr),
    .wdata(word_wdata), .hp_req(hp_req), .hp_slot(hp_slot),
    .hp_insert(hp_insert), .rdata(word_rdata)
  );

  gpe_hp_eject u_eject (
    .clk(clk), .rst_n(rst_n_i), .wr_en(word_wr), .addr(word_addr),
    .wdata(word_wdata), .stb(eject_stb), .slot(eject_slot)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sci_q <= 1'b0;
    else          sci_q <= hp_req && en_nxt[HP_BIT];
  end

  assign sci = sci_q;

  p_sci_cause_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    sci |-> $past(hp_req));
  p_sci_masked_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    !hp_req |=> !sci);
endmodule

// File: tb/test_gpe_hotplug_events.sv
module test_gpe_hotplug_events;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_wr;
  logic [1:0]  byte_addr;
  logic [7:0]  byte_wdata, byte_rdata;
  logic        word_wr;
  logic [3:0]  word_addr;
  logic [31:0] word_wdata, word_rdata;
  logic        hp_req, hp_insert;
  logic [4:0]  hp_slot;
  logic        sci, eject_stb;
  logic [4:0]  eject_slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_sts, m_en;
  logic [31:0] m_ins, m_rem;
  logic        e_sci, e_ej;
  logic [4:0]  e_slot;

  always #2 clk = ~clk;

  gpe_hotplug_events i_gpe_hotplug_events (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_addr(byte_addr),
    .byte_wdata(byte_wdata), .byte_rdata(byte_rdata), .word_wr(word_wr),
    .word_addr(word_addr), .word_wdata(word_wdata), .word_rdata(word_rdata),
    .hp_req(hp_req), .hp_slot(hp_slot), .hp_insert(hp_insert), .sci(sci),
    .eject_stb(eject_stb), .eject_slot(eject_slot)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [1:0] a);
    logic [15:0] r;
    r = a[1] ? m_en : m_sts;
    return a[0] ? r[15:8] : r[7:0];
  endfunction

  function automatic logic [31:0] exp_word(input logic [3:0] a);
    if (a == 4'h0) return m_ins;
    if (a == 4'h4) return m_rem;
    return 32'h0;
  endfunction

  function automatic logic [4:0] first_one(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  // One cycle: drive at the falling edge, check reads, advance model, check outputs.
  task automatic step(input bit bw, input logic [1:0] ba, input logic [7:0] bd,
                      input bit ww, input logic [3:0] wa, input logic [31:0] wd,
                      input bit hp, input logic [4:0] hs, input bit hi);
    logic [15:0] n_sts, n_en;
    logic [31:0] n_ins, n_rem;
    byte_wr = bw; byte_addr = ba; byte_wdata = bd;
    word_wr = ww; word_addr = wa; word_wdata = wd;
    hp_req = hp; hp_slot = hs; hp_insert = hi;
    #1;
    check("R2 R3 R4 byte read", {24'h0, byte_rdata}, {24'h0, exp_byte(ba)});
    check("R5 R6 word read", word_rdata, exp_word(wa));
    n_sts = m_sts; n_en = m_en; n_ins = m_ins; n_rem = m_rem;
    if (bw && !ba[1]) begin
      if (ba[0]) n_sts[15:8] = m_sts[15:8] & ~bd;
      else       n_sts[7:0]  = m_sts[7:0]  & ~bd;
    end
    if (bw && ba[1]) begin
      if (ba[0]) n_en[15:8] = bd;
      else       n_en[7:0]  = bd;
    end
    if (ww && wa == 4'h0) n_ins = wd;
    if (ww && wa == 4'h4) n_rem = wd;
    if (hp) begin  // R9: hotplug last
      n_ins = 32'h0; n_rem = 32'h0;
      if (hi) n_ins[hs] = 1'b1; else n_rem[hs] = 1'b1;
      n_sts[1] = 1'b1;
    end
    e_sci  = hp && n_en[1];
    e_ej   = ww && wa == 4'h8 && wd != 32'h0;
    e_slot = first_one(wd);
    m_sts = n_sts; m_en = n_en; m_ins = n_ins; m_rem = n_rem;
    @(posedge clk);
    @(negedge clk);
    check("R7 sci", {31'h0, sci}, {31'h0, e_sci});
    check("R8 eject_stb", {31'h0, eject_stb}, {31'h0, e_ej});
    if (e_ej) check("R8 eject_slot", {27'h0, eject_slot}, {27'h0, e_slot});
  endtask

  task automatic idle();
    step(0, 2'd0, 8'h0, 0, 4'h0, 32'h0, 0, 5'd0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    byte_wr = 0; byte_addr = 0; byte_wdata = 0;
    word_wr = 0; word_addr = 0; word_wdata = 0;
    hp_req = 0; hp_slot = 0; hp_insert = 0;
    m_sts = 0; m_en = 0; m_ins = 0; m_rem = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sci", {31'h0, sci}, 32'h0);
    check("R1 eject_stb", {31'h0, eject_stb}, 32'h0);
    for (int a = 0; a < 4; a++) step(0, 2'(a), 8'h0, 0, 4'h0, 32'h0, 0, 5'd0, 0);
    step(0, 2'd0, 8'h0, 0, 4'h4, 32'h0, 0, 5'd0, 0);
    // R6 R7: request while masked gives no sci
    step(0, 2'd0, 8'h0, 0, 4'h0, 32'h0, 1, 5'd31, 1);
    idle();
    // R4: enable bit 1 in low byte, then high byte leaves it
    step(1, 2'd2, 8'h02, 0, 4'h0, 32'h0, 0, 5'd0, 0);
    step(1, 2'd3, 8'hA5, 0, 4'h4, 32'h0, 0, 5'd0, 0);
    // R6 R7: removal of slot 0 raises sci
    step(0, 2'd2, 8'h0, 0, 4'h4, 32'h0, 1, 5'd0, 0);
    step(0, 2'd0, 8'h0, 0, 4'h4, 32'h0, 0, 5'd0, 0);
    step(0, 2'd0, 8'h0, 0, 4'h0, 32'h0, 0, 5'd0, 0);
    // R3: high-byte clear leaves bit 1; low-byte clear of bit 1
    step(1, 2'd1, 8'hFF, 0, 4'h0, 32'h0, 0, 5'd0, 0);
    step(1, 2'd0, 8'hFD, 0, 4'h0, 32'h0, 0, 5'd0, 0);
    step(1, 2'd0, 8'h02, 0, 4'h0, 32'h0, 0, 5'd0, 0);
    idle();
    // R9: clear of bit 1 and bitmap write collide with a request
    step(1, 2'd0, 8'h02, 1, 4'h0, 32'hFFFF_FFFF, 1, 5'd17, 1);
    step(0, 2'd0, 8'h0, 0, 4'h0, 32'h0, 0, 5'd0, 0);
    // R4 R7: enable cleared in the same cycle as a request suppresses sci
    step(1, 2'd2, 8'h00, 0, 4'h4, 32'h0, 1, 5'd9, 0);
    step(1, 2'd2, 8'h02, 0, 4'h4, 32'h0, 1, 5'd30, 0);
    // R5: bitmap writes and an ignored offset
    step(0, 2'd0, 8'h0, 1, 4'h4, 32'hDEAD_BEEF, 0, 5'd0, 0);
    step(0, 2'd0, 8'h0, 1, 4'hC, 32'h1234_5678, 0, 5'd0, 0);
    step(0, 2'd0, 8'h0, 0, 4'h4, 32'h0, 0, 5'd0, 0);
    // R8: eject of zero, multi-bit, top bit
    step(0, 2'd0, 8'h0, 1, 4'h8, 32'h0, 0, 5'd0, 0);
    step(0, 2'd0, 8'h0, 1, 4'h8, 32'h0000_0300, 0, 5'd0, 0);
    step(0, 2'd0, 8'h0, 1, 4'h8, 32'h8000_0000, 0, 5'd0, 0);
    step(0, 2'd0, 8'h0, 0, 4'h8, 32'h0, 0, 5'd0, 0);
    // Random mix across R2-R9
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] wa;
      logic [31:0] wd;
      case ($urandom_range(0, 3))
        0: wa = 4'h0;
        1: wa = 4'h4;
        2: wa = 4'h8;
        default: wa = 4'($urandom);
      endcase
      wd = ($urandom_range(0, 5) == 0) ? 32'h0 : $urandom;
      if ($urandom_range(0, 1) == 1) wd = wd & (32'hFFFF_FFFF << $urandom_range(0, 31));
      step($urandom_range(0, 2) == 0, 2'($urandom), 8'($urandom),
           $urandom_range(0, 2) == 0, wa, wd,
           $urandom_range(0, 4) == 0, 5'($urandom), 1'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule